// File: doc/BRIEF.md
# I2C Target Controller with CPU Register Access

This block is a byte-oriented I2C target (slave) that a local processor runs through four small registers: control, status, data and own-address. It watches the SDA and SCL inputs for START, repeated START and STOP conditions. It compares the first seven bits after each START with its programmed seven-bit address and acknowledges only a match. After every completed address or data byte it raises an interrupt flag and holds SCL low. The bus stays stalled until software touches the data register in the direction it has selected.

The open-drain pads sit outside the block. Each line comes in as a plain input, and the block drives it low through an output-enable, so the pad is low when the enable is 1. A write to the data register sends a byte in transmit mode. A read of the data register collects a byte, or serves as a dummy access, in receive mode. When the block is transmitting, it records the acknowledge bit that the master returns after each byte.

Top module: `i2c_tgt_ctrl`

## Requirements
- R1: A falling SDA while SCL is high is a START. The block treats the next byte as an address, also when no STOP came first. It sets status bit 5 (busy) on START and clears it on a rising SDA while SCL is high (STOP).
- R2: Own-address register (select 3) bits [6:0] are compared with the first seven bits received after a START, MSB first. On a match the block drives SDA low during the ninth clock. On a mismatch it leaves SDA released, raises no interrupt and holds no clock until the next START or STOP.
- R3: When the ninth SCL of a matching address falls, status bit 6 (addressed) and status bit 1 (interrupt flag) are set. Status bit 2 takes the address byte's R/W bit.
- R4: Any write to the control register (select 0) clears status bit 6, and so does every completed data byte.
- R5: After every completed acknowledged byte, address or data, the block holds SCL low (scl_oe_o = 1).
- R6: With control bit 4 = 0 (receive), a read of the data register (select 2) releases SCL and a write does not. Each received data byte is acknowledged and can be read from the data register.
- R7: With control bit 4 = 1 (transmit), a data-register write loads the byte, sends it MSB first and releases SCL. A data-register read does not release SCL.
- R8: Status bit 0 holds the master's ninth bit after each transmitted byte, and 1 means the master wants no more data. Switching to receive and then reading the data register releases SCL, so the master can send STOP.
- R9: Writing a status byte with bit 1 = 1 clears the interrupt flag. irq_o is the flag ANDed with control bit 6.
- R10: Status bit 7 (byte done) is set when the ninth SCL falls. It is cleared when SCL is released, or on START or STOP.
- R11: The block changes sda_oe_o only while the synchronized SCL is low.
- R12: With control bit 7 (enable) = 0, the block drives neither line and reports no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data, 3 own address |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume that a master moves SDA only while SCL is low, except to make START or STOP. They also assume that each SCL level lasts longer than the synchronizer latency, so that every edge is seen exactly once. The stimulus comes from a bit-level master that keeps each SCL phase several clocks long. It honours clock stretching by waiting for the line to go high, and it changes SDA only in the low phase. Register strobes are one clock wide and are applied only between bytes, while the block holds SCL.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 7;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam int SEL_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_OWN  = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_HOLD,
        ST_TXLD,
        ST_SEND,
        ST_MACK,
        ST_SKIP
    } eng_st_e;

    // control bit positions
    localparam int C_EN = 7;
    localparam int C_IE = 6;
    localparam int C_TX = 4;
    // status bit positions
    localparam int S_DONE = 7;
    localparam int S_AAS  = 6;
    localparam int S_BUSY = 5;
    localparam int S_SRW  = 2;
    localparam int S_IFLG = 1;
    localparam int S_RXAK = 0;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_c;
        logic [STAGES-1:0] sda_c;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.scl_c = {sync_q.scl_c[STAGES-2:0], scl_i};
        sync_d.sda_c = {sync_q.sda_c[STAGES-2:0], sda_i};
        sync_d.scl_p = sync_q.scl_c[STAGES-1];
        sync_d.sda_p = sync_q.sda_c[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign scl_s     = sync_q.scl_c[STAGES-1];
    assign sda_s     = sync_q.sda_c[STAGES-1];
    assign scl_rise  = !sync_q.scl_p && scl_s;
    assign scl_fall  = sync_q.scl_p && !scl_s;
    assign start_det = sync_q.scl_p && scl_s && sync_q.sda_p && !sda_s;
    assign stop_det  = sync_q.scl_p && scl_s && !sync_q.sda_p && sda_s;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              tx_sel,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [BYTE_W-1:0] wdata,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              rxak,
    output logic              ev_byte,
    output logic              ev_addr,
    output logic              ev_rxd,
    output logic              ev_srw,
    output logic              ev_rel,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W);

    typedef struct packed {
        eng_st_e           st;
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              is_addr;
        logic              scl_oe;
        logic              sda_oe;
        logic              busy;
        logic              rxak;
        logic              ev_byte;
        logic              ev_addr;
        logic              ev_rxd;
        logic              ev_srw;
        logic              ev_rel;
        logic [BYTE_W-1:0] rx_byte;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d         = eng_q;
        eng_d.ev_byte = 1'b0;
        eng_d.ev_addr = 1'b0;
        eng_d.ev_rxd  = 1'b0;
        eng_d.ev_rel  = 1'b0;
        if (!en) begin
            eng_d.st     = ST_IDLE;
            eng_d.scl_oe = 1'b0;
            eng_d.sda_oe = 1'b0;
            eng_d.busy   = 1'b0;
        end else if (start_det) begin
            eng_d.st      = ST_RECV;
            eng_d.is_addr = 1'b1;
            eng_d.cnt     = '0;
            eng_d.scl_oe  = 1'b0;
            eng_d.sda_oe  = 1'b0;
            eng_d.busy    = 1'b1;
        end else if (stop_det) begin
            eng_d.st     = ST_IDLE;
            eng_d.scl_oe = 1'b0;
            eng_d.sda_oe = 1'b0;
            eng_d.busy   = 1'b0;
        end else begin
            unique case (eng_q.st)
                ST_RECV: begin
                    if (scl_rise && eng_q.cnt < CNT_LAST) begin
                        eng_d.shreg = {eng_q.shreg[BYTE_W-2:0], sda_s};
                        eng_d.cnt   = eng_q.cnt + 1'b1;
                    end else if (scl_fall && eng_q.cnt == CNT_LAST) begin
                        if (!eng_q.is_addr || eng_q.shreg[BYTE_W-1:1] == own_addr) begin
                            eng_d.sda_oe = 1'b1;
                            eng_d.st     = ST_ACK;
                        end else begin
                            eng_d.st = ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        eng_d.sda_oe  = 1'b0;
                        eng_d.scl_oe  = 1'b1;
                        eng_d.st      = ST_HOLD;
                        eng_d.cnt     = '0;
                        eng_d.ev_byte = 1'b1;
                        eng_d.ev_addr = eng_q.is_addr;
                        eng_d.ev_rxd  = !eng_q.is_addr;
                        eng_d.ev_srw  = eng_q.shreg[0];
                        eng_d.rx_byte = eng_q.shreg;
                        eng_d.is_addr = 1'b0;
                    end
                end
                ST_HOLD: begin
                    if (tx_sel && dat_wr) begin
                        eng_d.shreg  = wdata;
                        eng_d.sda_oe = !wdata[BYTE_W-1];
                        eng_d.st     = ST_TXLD;
                        eng_d.ev_rel = 1'b1;
                    end else if (!tx_sel && dat_rd) begin
                        eng_d.scl_oe = 1'b0;
                        eng_d.st     = ST_RECV;
                        eng_d.cnt    = '0;
                        eng_d.ev_rel = 1'b1;
                    end
                end
                ST_TXLD: begin
                    eng_d.scl_oe = 1'b0;
                    eng_d.cnt    = '0;
                    eng_d.st     = ST_SEND;
                end
                ST_SEND: begin
                    if (scl_rise && eng_q.cnt < CNT_LAST) begin
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end else if (scl_fall && eng_q.cnt != '0) begin
                        if (eng_q.cnt == CNT_LAST) begin
                            eng_d.sda_oe = 1'b0;
                            eng_d.st     = ST_MACK;
                        end else begin
                            eng_d.shreg  = {eng_q.shreg[BYTE_W-2:0], 1'b0};
                            eng_d.sda_oe = !eng_q.shreg[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        eng_d.rxak = sda_s;
                    end else if (scl_fall) begin
                        eng_d.scl_oe  = 1'b1;
                        eng_d.st      = ST_HOLD;
                        eng_d.ev_byte = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{st: ST_IDLE, default: '0};
        else        eng_q <= eng_d;
    end

    assign scl_oe  = eng_q.scl_oe;
    assign sda_oe  = eng_q.sda_oe;
    assign busy    = eng_q.busy;
    assign rxak    = eng_q.rxak;
    assign ev_byte = eng_q.ev_byte;
    assign ev_addr = eng_q.ev_addr;
    assign ev_rxd  = eng_q.ev_rxd;
    assign ev_srw  = eng_q.ev_srw;
    assign ev_rel  = eng_q.ev_rel;
    assign rx_byte = eng_q.rx_byte;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OWN_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              ev_byte,
    input  logic              ev_addr,
    input  logic              ev_rxd,
    input  logic              ev_srw,
    input  logic              ev_rel,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              busy,
    input  logic              rxak,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              en,
    output logic              ie,
    output logic              tx_sel,
    output logic [ADDR_W-1:0] own_addr,
    output logic              dat_wr,
    output logic              dat_rd,
    output logic              aas,
    output logic              iflag
);
    typedef struct packed {
        logic              en;
        logic              ie;
        logic              tx;
        logic [ADDR_W-1:0] own;
        logic [BYTE_W-1:0] data;
        logic              done;
        logic              aas;
        logic              srw;
        logic              iflag;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  wr_ctrl, wr_stat, wr_own;

    assign wr_ctrl = reg_wr && reg_sel == SEL_CTRL;
    assign wr_stat = reg_wr && reg_sel == SEL_STAT;
    assign wr_own  = reg_wr && reg_sel == SEL_OWN;
    assign dat_wr  = reg_wr && reg_sel == SEL_DATA;
    assign dat_rd  = reg_rd && reg_sel == SEL_DATA;

    always_comb begin
        rg_d = rg_q;
        if (wr_ctrl) begin
            rg_d.en  = reg_wdata[C_EN];
            rg_d.ie  = reg_wdata[C_IE];
            rg_d.tx  = reg_wdata[C_TX];
            rg_d.aas = 1'b0;
        end
        if (wr_own)  rg_d.own  = reg_wdata[ADDR_W-1:0];
        if (dat_wr)  rg_d.data = reg_wdata;
        if (wr_stat && reg_wdata[S_IFLG]) rg_d.iflag = 1'b0;
        if (ev_rel || start_det || stop_det) rg_d.done = 1'b0;
        if (start_det) rg_d.aas = 1'b0;
        if (ev_byte) begin
            rg_d.done  = 1'b1;
            rg_d.iflag = 1'b1;
            if (ev_addr) begin
                rg_d.aas = 1'b1;
                rg_d.srw = ev_srw;
            end else begin
                rg_d.aas = 1'b0;
            end
        end
        if (ev_rxd) rg_d.data = rx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '{own: OWN_RESET, default: '0};
        else        rg_q <= rg_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_CTRL: begin
                reg_rdata[C_EN] = rg_q.en;
                reg_rdata[C_IE] = rg_q.ie;
                reg_rdata[C_TX] = rg_q.tx;
            end
            SEL_STAT: begin
                reg_rdata[S_DONE] = rg_q.done;
                reg_rdata[S_AAS]  = rg_q.aas;
                reg_rdata[S_BUSY] = busy;
                reg_rdata[S_SRW]  = rg_q.srw;
                reg_rdata[S_IFLG] = rg_q.iflag;
                reg_rdata[S_RXAK] = rxak;
            end
            SEL_DATA: reg_rdata = rg_q.data;
            default:  reg_rdata[ADDR_W-1:0] = rg_q.own;
        endcase
    end

    assign en       = rg_q.en;
    assign ie       = rg_q.ie;
    assign tx_sel   = rg_q.tx;
    assign own_addr = rg_q.own;
    assign aas      = rg_q.aas;
    assign iflag    = rg_q.iflag;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] OWN_RESET   = 7'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq_o,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe_o,
    output logic              sda_oe_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              en, ie, tx_sel, dat_wr, dat_rd, aas, iflag;
    logic [ADDR_W-1:0] own_addr;
    logic              busy, rxak, ev_byte, ev_addr, ev_rxd, ev_srw, ev_rel;
    logic [BYTE_W-1:0] rx_byte;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_tgt_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .own_addr (own_addr),
        .tx_sel   (tx_sel),
        .dat_wr   (dat_wr),
        .dat_rd   (dat_rd),
        .wdata    (reg_wdata),
        .scl_oe   (scl_oe_o),
        .sda_oe   (sda_oe_o),
        .busy     (busy),
        .rxak     (rxak),
        .ev_byte  (ev_byte),
        .ev_addr  (ev_addr),
        .ev_rxd   (ev_rxd),
        .ev_srw   (ev_srw),
        .ev_rel   (ev_rel),
        .rx_byte  (rx_byte)
    );

    i2c_tgt_regs #(.OWN_RESET(OWN_RESET)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_sel  (reg_sel),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ev_byte  (ev_byte),
        .ev_addr  (ev_addr),
        .ev_rxd   (ev_rxd),
        .ev_srw   (ev_srw),
        .ev_rel   (ev_rel),
        .rx_byte  (rx_byte),
        .busy     (busy),
        .rxak     (rxak),
        .start_det(start_det),
        .stop_det (stop_det),
        .en       (en),
        .ie       (ie),
        .tx_sel   (tx_sel),
        .own_addr (own_addr),
        .dat_wr   (dat_wr),
        .dat_rd   (dat_rd),
        .aas      (aas),
        .iflag    (iflag)
    );

    assign irq_o = iflag && ie;
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
    import i2c_tgt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              scl_s,
    input logic              start_det,
    input logic              busy,
    input logic              sda_oe,
    input logic              scl_oe,
    input logic              ev_byte,
    input logic              ev_addr,
    input logic              aas,
    input logic              iflag,
    input logic              irq_o,
    input logic [SEL_W-1:0]  reg_sel,
    input logic              reg_wr,
    input logic [BYTE_W-1:0] reg_wdata
);
    assert_busy_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start_det) |=> busy);

    assert_ctrl_clears_aas_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_CTRL && !ev_addr) |=> !aas);

    assert_data_byte_no_aas_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_byte && !ev_addr) |=> !aas);

    assert_hold_on_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iflag) |-> scl_oe);

    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_STAT && reg_wdata[S_IFLG] && !ev_byte) |=> !irq_o);

    assert_sda_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (sda_oe != $past(sda_oe))) |-> !$past(scl_s));

    assert_quiet_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sda_oe && !scl_oe));
endmodule

bind i2c_tgt_ctrl i2c_tgt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .scl_s    (scl_s),
    .start_det(start_det),
    .busy     (busy),
    .sda_oe   (sda_oe_o),
    .scl_oe   (scl_oe_o),
    .ev_byte  (ev_byte),
    .ev_addr  (ev_addr),
    .aas      (aas),
    .iflag    (iflag),
    .irq_o    (irq_o),
    .reg_sel  (reg_sel),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata)
);

// File: tb/tb_i2c_tgt_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_tgt_ctrl;
    localparam int H = 8;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] reg_sel = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic irq_o, scl_oe_o, sda_oe_o;
    logic m_scl = 1'b1, m_sda = 1'b1;
    wire  scl_line = m_scl && !scl_oe_o;
    wire  sda_line = m_sda && !sda_oe_o;

    int n_chk = 0, n_bad = 0, r11_viol = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    i2c_tgt_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
    );

    // R11 monitor: target must not move its SDA drive while the line SCL is high
    logic sda_oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe_o != sda_oe_prev && scl_line) r11_viol++;
        sda_oe_prev <= sda_oe_o;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_wr(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cpu_rd(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic scl_high();
        m_scl = 1'b1;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; wait_clks(H);
        scl_high(); wait_clks(H);
        m_sda = 1'b0; wait_clks(H);
        m_scl = 1'b0; wait_clks(H);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; wait_clks(H);
        scl_high(); wait_clks(H);
        m_sda = 1'b1; wait_clks(H);
    endtask

    task automatic m_bit_out(input logic b);
        m_sda = b; wait_clks(H);
        scl_high(); wait_clks(H);
        m_scl = 1'b0; wait_clks(H);
    endtask

    task automatic m_bit_in(output logic b);
        m_sda = 1'b1; wait_clks(H);
        scl_high(); wait_clks(H/2);
        b = sda_line; wait_clks(H/2);
        m_scl = 1'b0; wait_clks(H);
    endtask

    task automatic m_write(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) m_bit_out(v[i]);
        m_bit_in(ack);
    endtask

    task automatic m_read(output logic [7:0] v, input logic ack);
        for (int i = 7; i >= 0; i--) m_bit_in(v[i]);
        m_bit_out(ack);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) ^ (i << 5));
    endfunction

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        finish_run();
    end

    initial begin
        logic [7:0] v, got;
        logic ack;
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(3);

        // reset state
        cpu_rd(2'd0, v); chk("reset ctrl R12", v, 0);
        cpu_rd(2'd1, v); chk("reset status R10", v, 0);
        cpu_rd(2'd3, v); chk("reset own R2", v, 8'h2A);
        chk("reset irq R9", irq_o, 0);
        chk("reset scl_oe R5", scl_oe_o, 0);
        chk("reset sda_oe R11", sda_oe_o, 0);

        // R12: disabled block ignores a matching address
        cpu_wr(2'd3, {1'b0, OWN});
        m_start();
        m_write({OWN, 1'b0}, ack);
        chk("R12 no ack when off", ack, 1);
        cpu_rd(2'd1, v); chk("R12 status off", v, 0);
        chk("R12 irq off", irq_o, 0);
        m_stop();

        // enable with interrupts
        cpu_wr(2'd0, 8'hC0);

        // R2/R3/R1: sweep all addresses
        for (int a = 0; a < 128; a++) begin
            logic match;
            match = (7'(a) == OWN);
            m_start();
            m_write({7'(a), 1'b0}, ack);
            chk($sformatf("R2 ack addr %0h", a), ack, match ? 0 : 1);
            wait_clks(4);
            cpu_rd(2'd1, v);
            chk($sformatf("R3 status addr %0h", a), v, match ? 8'hE2 : 8'h20);
            chk($sformatf("R5 hold addr %0h", a), scl_oe_o, match ? 1 : 0);
            chk($sformatf("R9 irq addr %0h", a), irq_o, match ? 1 : 0);
            if (match) begin
                cpu_rd(2'd2, v);
                cpu_wr(2'd1, 8'h02);
            end
            m_stop();
            cpu_rd(2'd1, v);
            chk($sformatf("R1 stop addr %0h", a), v, match ? 8'h40 : 8'h00);
        end

        // master writes data bytes: R4, R5, R6, R10
        m_start();
        m_write({OWN, 1'b0}, ack);
        chk("R2 write addr ack", ack, 0);
        cpu_rd(2'd1, v); chk("R3 aas set", v, 8'hE2);
        cpu_wr(2'd0, 8'hC0);
        cpu_rd(2'd1, v); chk("R4 ctrl write clears aas", v, 8'hA2);
        cpu_wr(2'd1, 8'h02);
        cpu_rd(2'd1, v); chk("R9 flag cleared", v, 8'hA0);
        cpu_rd(2'd2, v);
        wait_clks(2);
        chk("R6 read releases scl", scl_oe_o, 0);
        cpu_rd(2'd1, v); chk("R10 done cleared on release", v, 8'h20);
        for (int i = 0; i < 12; i++) begin
            logic [7:0] b;
            b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : pat(i);
            m_write(b, ack);
            chk($sformatf("R6 data ack %0d", i), ack, 0);
            wait_clks(4);
            chk($sformatf("R5 data hold %0d", i), scl_oe_o, 1);
            cpu_rd(2'd1, v);
            chk($sformatf("R4 data status %0d", i), v, 8'hA2);
            if (i == 2) begin
                cpu_wr(2'd0, 8'h80);
                chk("R9 irq masked", irq_o, 0);
                cpu_wr(2'd0, 8'hC0);
                chk("R9 irq unmasked", irq_o, 1);
                cpu_wr(2'd2, 8'h33);
                wait_clks(H);
                chk("R6 write keeps hold", scl_oe_o, 1);
                b = 8'h33;
            end
            cpu_wr(2'd1, 8'h02);
            chk($sformatf("R9 irq cleared %0d", i), irq_o, 0);
            cpu_rd(2'd2, v);
            chk($sformatf("R6 data value %0d", i), v, b);
        end

        // repeated START to a read: R1, R3, R7, R8
        m_start();
        m_write({OWN, 1'b1}, ack);
        chk("R1 repeated start addr ack", ack, 0);
        cpu_rd(2'd1, v); chk("R3 srw set", v, 8'hE6);
        cpu_wr(2'd0, 8'hD0);
        cpu_wr(2'd1, 8'h02);
        cpu_rd(2'd2, v);
        wait_clks(H);
        chk("R7 read keeps hold", scl_oe_o, 1);
        for (int i = 0; i < 10; i++) begin
            logic [7:0] b;
            logic last;
            b = (i == 0) ? 8'h80 : (i == 1) ? 8'h01 : pat(i + 20);
            last = (i == 9);
            cpu_wr(2'd2, b);
            m_read(got, last);
            chk($sformatf("R7 tx byte %0d", i), got, b);
            wait_clks(4);
            cpu_rd(2'd1, v);
            chk($sformatf("R8 rxak status %0d", i), v, last ? 8'hA7 : 8'hA6);
            chk($sformatf("R5 tx hold %0d", i), scl_oe_o, 1);
            cpu_wr(2'd1, 8'h02);
        end
        cpu_wr(2'd0, 8'hC0);
        cpu_rd(2'd2, v);
        wait_clks(2);
        chk("R8 dummy read releases", scl_oe_o, 0);
        m_stop();
        cpu_rd(2'd1, v);
        chk("R1 busy cleared by stop", v, 8'h05);

        chk("R11 sda changes with scl low", r11_viol, 0);
        finish_run();
    end
endmodule